// File: doc/BRIEF.md
# Third-Order Fractional Divide-Value Modulator

This block sets the per-cycle divide ratio of a fractional-N synthesizer's feedback divider. It runs once per reference cycle. It takes an integer divide value and a fractional numerator with a fixed denominator of 130, and returns the integer value plus a small signed correction. Averaged over time, the correction equals the fraction. The quantisation error is pushed to high offsets by three cascaded first-order accumulators, each wrapping at 130, whose overflow bits are combined through first and second differences.

The loop can cut its charge-pump current in half in a single step. To keep the slow loop from seeing that cut, the block accepts a scale strobe one reference cycle earlier. On a strobe cycle the second and third accumulators double their stored residues, wrapping at 130. The first accumulator and the overflow history keep their values, and the output repeats its last value. The larger residues then drive a wider correction on the following cycles, and normal behaviour returns within a cycle or two.

Top module: `sdm3_mod`

## Requirements
- R1: While `rst` is high, `div_o` reads 0 and all accumulators and overflow history clear. A `scale` pulse during reset has no effect: the output sequence after release is the same as that of a reset without the pulse.
- R2: On every non-scale cycle, stage 1 adds `frac` to its residue, stage 2 adds stage 1's new residue, and stage 3 adds stage 2's new residue. Each sum at or above 130 has 130 subtracted and sets that stage's overflow bit c1, c2 or c3. Every residue stays below 130.
- R3: On the clock edge of a non-scale cycle, `div_o` takes the value `n_int` + c1 + (c2 − c2') + (c3 − 2·c3' + c3''). Here c2' and c3' are the c2 and c3 of the previous non-scale cycle, and c3'' is the c3 of the one before that.
- R4: After a non-scale cycle that follows reset, `div_o` − `n_int` lies in −3 to +4. `n_int` is taken to be at least 3.
- R5: On a cycle with `scale` high outside reset, the stage-2 and stage-3 residues become 2·residue mod 130. The stage-1 residue, the overflow history and `div_o` hold their values.
- R6: Take any 1040 consecutive non-scale cycles with a constant `frac`. The sum of `div_o` − `n_int` over them differs from 8·`frac` by at most 3.
- R7: With `frac` = 0 from reset and no scale pulses, `div_o` equals `n_int` on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| n_int | input | INT_W (8) | Integer divide value |
| frac | input | FRAC_W (7) | Fractional numerator over 130 |
| scale | input | 1 | Double the stage-2 and stage-3 residues this cycle |
| div_o | output | INT_W+1 (9) | Registered instantaneous divide value |

## Verification
A stage residue that is wrong alters later overflow bits, so `div_o` parts from the independent model within one to three edges. Stage 3 reaches the output through a second difference and can leave it at the model's value for a cycle. A broken scale path shows up at the edge after the strobe, either as a failure to hold or as a different correction on the next cycles. A bias in stage 1 shows up as a drift in the 1040-cycle sum even when the local pattern looks plausible.

// File: rtl/sdm3_pkg.sv
package sdm3_pkg;
    // Width of the signed per-cycle correction (covers -3..+4)
    localparam int OFF_W   = 4;
    localparam int NSTAGE  = 3;
    localparam int OFF_MIN = -3;
    localparam int OFF_MAX = 4;
endpackage

// File: rtl/sdm3_stage.sv
module sdm3_stage #(
    parameter int MOD      = 130,
    parameter int ACC_W    = 8,
    parameter bit SCALABLE = 1'b1
) (
    input  logic [ACC_W-1:0] acc_q,
    input  logic [ACC_W-1:0] addend,
    input  logic             scale,
    output logic [ACC_W-1:0] acc_d,
    output logic             carry
);
    localparam logic [ACC_W:0] MODV = (ACC_W+1)'(MOD);

    logic [ACC_W:0]   sum_w;
    logic [ACC_W:0]   wrap_w;
    logic [ACC_W-1:0] alt_val;

    always_comb begin
        sum_w  = {1'b0, acc_q} + {1'b0, addend};
        carry  = (sum_w >= MODV);
        wrap_w = carry ? (sum_w - MODV) : sum_w;
    end

    generate
        if (SCALABLE) begin : g_dbl
            logic [ACC_W:0] dbl_w;
            logic [ACC_W:0] dbl_wrap;
            always_comb begin
                dbl_w    = {acc_q, 1'b0};
                dbl_wrap = (dbl_w >= MODV) ? (dbl_w - MODV) : dbl_w;
                alt_val  = dbl_wrap[ACC_W-1:0];
            end
        end else begin : g_hold
            always_comb alt_val = acc_q;
        end
    endgenerate

    always_comb acc_d = scale ? alt_val : wrap_w[ACC_W-1:0];
endmodule

// File: rtl/sdm3_shaper.sv
module sdm3_shaper
    import sdm3_pkg::*;
(
    input  logic                    c1,
    input  logic                    c2,
    input  logic                    c3,
    input  logic                    c2_h,
    input  logic                    c3_h1,
    input  logic                    c3_h2,
    output logic signed [OFF_W-1:0] offset
);
    logic signed [OFF_W-1:0] t1, t2a, t2b, t3a, t3b, t3c;

    always_comb begin
        t1     = $signed({{(OFF_W-1){1'b0}}, c1});
        t2a    = $signed({{(OFF_W-1){1'b0}}, c2});
        t2b    = $signed({{(OFF_W-1){1'b0}}, c2_h});
        t3a    = $signed({{(OFF_W-1){1'b0}}, c3});
        t3b    = $signed({{(OFF_W-2){1'b0}}, c3_h1, 1'b0});
        t3c    = $signed({{(OFF_W-1){1'b0}}, c3_h2});
        offset = t1 + (t2a - t2b) + (t3a - t3b + t3c);
    end
endmodule

// File: rtl/sdm3_mod.sv
module sdm3_mod
    import sdm3_pkg::*;
#(
    parameter int MOD    = 130,
    parameter int FRAC_W = 7,
    parameter int INT_W  = 8,
    localparam int ACC_W = $clog2(MOD),
    localparam int OUT_W = INT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INT_W-1:0]  n_int,
    input  logic [FRAC_W-1:0] frac,
    input  logic              scale,
    output logic [OUT_W-1:0]  div_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc1;
        logic [ACC_W-1:0] acc2;
        logic [ACC_W-1:0] acc3;
        logic             c2_h;
        logic             c3_h1;
        logic             c3_h2;
        logic [OUT_W-1:0] div;
    } state_t;

    localparam int FMAX = MOD - 1;

    state_t st_d, st_q;

    logic [ACC_W-1:0] acc_cur [NSTAGE];
    logic [ACC_W-1:0] acc_nxt [NSTAGE];
    logic [ACC_W-1:0] addend  [NSTAGE];
    logic             carry   [NSTAGE];
    logic [ACC_W-1:0] frac_lim;
    logic signed [OFF_W-1:0] offset;
    logic signed [OUT_W:0]   total;

    always_comb begin
        frac_lim   = (int'(frac) > FMAX) ? ACC_W'(FMAX) : ACC_W'(frac);
        acc_cur[0] = st_q.acc1;
        acc_cur[1] = st_q.acc2;
        acc_cur[2] = st_q.acc3;
        addend[0]  = frac_lim;
        addend[1]  = acc_nxt[0];
        addend[2]  = acc_nxt[1];
    end

    generate
        for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
            sdm3_stage #(
                .MOD      (MOD),
                .ACC_W    (ACC_W),
                .SCALABLE (g != 0)
            ) u_stage (
                .acc_q  (acc_cur[g]),
                .addend (addend[g]),
                .scale  (scale),
                .acc_d  (acc_nxt[g]),
                .carry  (carry[g])
            );
        end
    endgenerate

    sdm3_shaper u_shaper (
        .c1     (carry[0]),
        .c2     (carry[1]),
        .c3     (carry[2]),
        .c2_h   (st_q.c2_h),
        .c3_h1  (st_q.c3_h1),
        .c3_h2  (st_q.c3_h2),
        .offset (offset)
    );

    always_comb begin
        st_d      = st_q;
        st_d.acc1 = acc_nxt[0];
        st_d.acc2 = acc_nxt[1];
        st_d.acc3 = acc_nxt[2];
        total     = $signed({2'b00, n_int}) + {{(OUT_W+1-OFF_W){offset[OFF_W-1]}}, offset};
        if (!scale) begin
            st_d.c2_h  = carry[1];
            st_d.c3_h1 = carry[2];
            st_d.c3_h2 = st_q.c3_h1;
            st_d.div   = total[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign div_o = st_q.div;
endmodule

// File: rtl/sdm3_mod_chk.sv
module sdm3_mod_chk #(
    parameter int MOD   = 130,
    parameter int INT_W = 8,
    parameter int ACC_W = 8,
    parameter int OUT_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic [INT_W-1:0] n_int,
    input logic             scale,
    input logic [OUT_W-1:0] div_o,
    input logic [ACC_W-1:0] acc1,
    input logic [ACC_W-1:0] acc2,
    input logic [ACC_W-1:0] acc3
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: output still cleared on the first edge after reset release
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (div_o == '0));

    // R2: residues stay below the modulus
    assert_acc_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (int'(acc1) < MOD) && (int'(acc2) < MOD) && (int'(acc3) < MOD));

    // R4: correction range after a normal step
    assert_offset_range_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && !$past(scale)) |->
        ((int'(div_o) - int'($past(n_int)) >= -3) && (int'(div_o) - int'($past(n_int)) <= 4)));

    // R5: output holds across a scale cycle
    assert_scale_hold_R5: assert property (@(posedge clk) disable iff (rst)
        scale |=> $stable(div_o));
endmodule

bind sdm3_mod sdm3_mod_chk #(
    .MOD   (MOD),
    .INT_W (INT_W),
    .ACC_W (ACC_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .n_int (n_int),
    .scale (scale),
    .div_o (div_o),
    .acc1  (st_q.acc1),
    .acc2  (st_q.acc2),
    .acc3  (st_q.acc3)
);

// File: tb/sdm3_mod_tb.sv
`timescale 1ns/1ps
module sdm3_mod_tb;
    localparam int MOD = 130;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] n_int = 8'd100;
    logic [6:0] frac = '0;
    logic       scale = 1'b0;
    logic [8:0] div_o;

    int total_chk = 0;
    int bad_chk   = 0;
    bit finished  = 0;

    // reference state
    int m_a1, m_a2, m_a3, m_c2, m_c3a, m_c3b, m_div, m_off;

    always #2 clk = ~clk;

    sdm3_mod u_dut (
        .clk(clk), .rst(rst), .n_int(n_int), .frac(frac),
        .scale(scale), .div_o(div_o)
    );

    function automatic int wrap130(int v);
        return (v >= MOD) ? v - MOD : v;
    endfunction

    function automatic int ovf(int v);
        return (v >= MOD) ? 1 : 0;
    endfunction

    task automatic model_reset();
        m_a1 = 0; m_a2 = 0; m_a3 = 0;
        m_c2 = 0; m_c3a = 0; m_c3b = 0;
        m_div = 0; m_off = 0;
    endtask

    task automatic model_step(int n, int f, bit sc);
        int s1, s2, s3, c1, c2, c3;
        if (sc) begin
            m_a2 = wrap130(2 * m_a2);
            m_a3 = wrap130(2 * m_a3);
        end else begin
            s1 = m_a1 + f; c1 = ovf(s1); m_a1 = wrap130(s1);
            s2 = m_a2 + m_a1; c2 = ovf(s2); m_a2 = wrap130(s2);
            s3 = m_a3 + m_a2; c3 = ovf(s3); m_a3 = wrap130(s3);
            m_off = c1 + (c2 - m_c2) + (c3 - 2 * m_c3a + m_c3b);
            m_c3b = m_c3a; m_c3a = c3; m_c2 = c2;
            m_div = n + m_off;
        end
    endtask

    task automatic check(string req, int act, int exp);
        total_chk++;
        if (act != exp) begin
            bad_chk++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(bit pulse_scale);
        @(negedge clk);
        rst = 1'b1; scale = pulse_scale;
        repeat (3) @(negedge clk);
        check("R1 reset output", int'(div_o), 0);
        rst = 1'b0; scale = 1'b0;
        model_reset();
    endtask

    // inputs are set at a negedge, compared at the following negedge
    task automatic step(int n, int f, bit sc, string req);
        int prev;
        prev = int'(div_o);
        n_int = 8'(n); frac = 7'(f); scale = sc;
        @(posedge clk);
        @(negedge clk);
        model_step(n, f, sc);
        check(req, int'(div_o), m_div);
        if (sc) check("R5 hold on scale", int'(div_o), prev);
    endtask

    task automatic mean_run(int f, int n);
        int acc, off;
        acc = 0;
        for (int i = 0; i < 1040; i++) begin
            step(n, f, 1'b0, "R3 output sequence");
            off = int'(div_o) - n;
            acc += off;
            if (off < -3 || off > 4) check("R4 range", off, 0);
        end
        total_chk++;
        if (acc - 8 * f > 3 || acc - 8 * f < -3) begin
            bad_chk++;
            $display("FAIL R6 mean: actual=%0d expected=%0d", acc, 8 * f);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            bad_chk++;
            total_chk++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
            $finish;
        end
    end

    initial begin
        int n, f, sc;
        void'($urandom(32'd1234));
        model_reset();

        // R1: scale pulse during reset is ignored
        do_reset(1'b1);
        // R7: zero fraction gives a constant divide value
        for (int i = 0; i < 40; i++) begin
            step(57, 0, 1'b0, "R7 zero fraction");
            check("R7 equals n_int", int'(div_o), 57);
        end

        // R2/R3/R6: mean over full periods for several fractions
        do_reset(1'b0);
        mean_run(65, 120);
        mean_run(1, 30);
        mean_run(127, 200);
        mean_run(0, 3);

        // R5: directed scale pulses, including back-to-back
        do_reset(1'b0);
        for (int i = 0; i < 20; i++) step(90, 97, 1'b0, "R3 pre-scale");
        step(90, 97, 1'b1, "R5 scale");
        step(90, 97, 1'b0, "R5 after scale");
        step(90, 97, 1'b1, "R5 scale");
        step(90, 97, 1'b1, "R5 double scale");
        for (int i = 0; i < 10; i++) step(90, 97, 1'b0, "R5 recovery");

        // random mix
        do_reset(1'b1);
        for (int i = 0; i < 4000; i++) begin
            n  = 3 + int'($urandom_range(0, 250));
            f  = int'($urandom_range(0, 127));
            sc = ($urandom_range(0, 15) == 0) ? 1 : 0;
            step(n, f, sc[0], "R3 random");
            if (!sc[0] && ((int'(div_o) - n) < -3 || (int'(div_o) - n) > 4))
                check("R4 range random", int'(div_o) - n, 0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end
endmodule